// File: doc/BRIEF.md
# Exception and Interrupt Entry Controller

This block performs the architectural state change a 32-bit RISC core makes when it enters an exception handler or an external interrupt handler. The core presents its current program counter, its status word and a flag that marks an instruction sitting in a branch delay slot. It also raises a one-cycle synchronous exception request with a cause number, and level-sensitive hardware and timer interrupt lines. From these the block computes the saved return address, a saved copy of the status word, the new supervisor-mode status word and the handler address. It registers all of them and issues a redirect to the core, together with a translation-cache flush strobe.

The two interrupt lines are qualified by their enable bits in the status word, and the timer line wins when both qualify. A latched synchronous exception outranks any interrupt. A return-from-exception request reloads the program counter and status word from the saved copies in a single cycle. A cause number outside the legal range is rejected with an error pulse and leaves all saved state unchanged.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset every output is zero.
- R2: An `exc_req_i` pulse latches `exc_code_i`. The entry caused by it appears on the outputs one cycle after the request edge, with `epc_o` equal to `cur_pc_i` of that cycle. The latched request is then cleared, so one request gives exactly one entry.
- R3: When `in_dslot_i` is high at entry, `epc_o` is `cur_pc_i - 4`, bit 13 (delay-slot exception) is set in `redir_sr_o`, and `dslot_clr_o` pulses for one cycle.
- R4: For synchronous cause 12 (system call), `epc_o` gains 4 after any delay-slot correction. A system call in a delay slot therefore saves `cur_pc_i` unchanged.
- R5: On entry `esr_o` holds the complete status word that was presented in the entry cycle.
- R6: On entry `redir_sr_o` equals the old status word with bit 0 (supervisor) set and bits 1 (timer enable), 2 (interrupt enable), 5 (data translation enable) and 6 (instruction translation enable) cleared. All other bits are kept.
- R7: On entry `redir_pc_o` is the cause number shifted left by 8 and `taken_code_o` is the cause. A latched cause of 0, or one of 15 or more, instead pulses `bad_code_o`. In that case `redir_vld_o` stays low and `epc_o` and `esr_o` keep their values.
- R8: `hw_irq_i` causes entry with cause 8 only when status bit 2 is set. `tick_irq_i` causes entry with cause 5 only when status bit 1 is set. Either entry appears one cycle after the edge at which the line was sampled.
- R9: When both interrupt lines are high and both are enabled, cause 5 (timer) is taken.
- R10: `tlb_flush_o` pulses for one cycle with every entry and never with a return.
- R11: `rfe_i` causes `redir_vld_o` with `redir_pc_o` equal to `epc_o` and `redir_sr_o` equal to `esr_o`, one cycle later. It does not raise `tlb_flush_o`.
- R12: In one cycle a latched exception, legal or not, outranks an interrupt, and an interrupt outranks `rfe_i`. The losing request has no effect in that cycle. `redir_pc_o`, `redir_sr_o` and `taken_code_o` hold their values between redirects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cur_pc_i | input | 32 | Address of the current instruction |
| cur_sr_i | input | 32 | Current status word |
| in_dslot_i | input | 1 | Current instruction is in a branch delay slot |
| exc_req_i | input | 1 | One-cycle synchronous exception request |
| exc_code_i | input | 4 | Cause number of the request |
| hw_irq_i | input | 1 | External interrupt line |
| tick_irq_i | input | 1 | Timer interrupt line |
| rfe_i | input | 1 | Return-from-exception request |
| redir_vld_o | output | 1 | Redirect pulse to the core |
| redir_pc_o | output | 32 | Redirect target address |
| redir_sr_o | output | 32 | Status word to install with the redirect |
| epc_o | output | 32 | Saved return address |
| esr_o | output | 32 | Saved status word |
| tlb_flush_o | output | 1 | Translation-cache flush strobe |
| dslot_clr_o | output | 1 | Clears the core's delay-slot flag |
| bad_code_o | output | 1 | Illegal cause number rejected |
| taken_code_o | output | 4 | Cause number of the last entry |

## Verification
The bench aims at the address corrections. A system call inside a delay slot must save the unmodified address. A design that applied only one of the two corrections, or applied them in the wrong order, would save an address 4 off. The cause-number boundaries 0, 1, 14 and 15 are driven directly; a design with an off-by-one limit would either redirect to an illegal vector or reject a legal one. Interrupts are driven with each enable bit cleared, with both lines together, and in the same cycle as a pending exception and a return. A wrong gate would enter on a masked line, a wrong priority would show the hardware cause where the timer cause belongs, and a wrong ordering would let a return overwrite the saved state.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int XLEN   = 32;
    localparam int CODE_W = 4;

    // status word bit positions
    localparam int SR_SUPV  = 0;
    localparam int SR_TICKE = 1;
    localparam int SR_INTE  = 2;
    localparam int SR_DTRE  = 5;
    localparam int SR_ITRE  = 6;
    localparam int SR_DSLX  = 13;

    typedef struct packed {
        logic              vld;
        logic [CODE_W-1:0] code;
    } pend_t;

    typedef struct packed {
        pend_t             pend;
        logic              redir_vld;
        logic [XLEN-1:0]   redir_pc;
        logic [XLEN-1:0]   redir_sr;
        logic [XLEN-1:0]   epc;
        logic [XLEN-1:0]   esr;
        logic              flush;
        logic              dclr;
        logic              bad;
        logic [CODE_W-1:0] code;
    } state_t;

endpackage

// File: rtl/exc_irq_arb.sv
module exc_irq_arb #(
    parameter int CODE_W     = 4,
    parameter int TICK_CODE  = 5,
    parameter int HWINT_CODE = 8
) (
    input  logic              hw_irq_i,
    input  logic              tick_irq_i,
    input  logic              int_en_i,
    input  logic              tick_en_i,
    output logic              take_o,
    output logic [CODE_W-1:0] code_o
);
    logic hw_ok;
    logic tick_ok;

    always_comb begin
        hw_ok   = hw_irq_i & int_en_i;
        tick_ok = tick_irq_i & tick_en_i;
        take_o  = hw_ok | tick_ok;
        // timer source has the higher rank
        code_o  = tick_ok ? CODE_W'(TICK_CODE) : CODE_W'(HWINT_CODE);
    end
endmodule

// File: rtl/exc_code_check.sv
module exc_code_check #(
    parameter int CODE_W  = 4,
    parameter int NUM_EXC = 15
) (
    input  logic [CODE_W-1:0] code_i,
    output logic              legal_o
);
    localparam logic [CODE_W:0] LIMIT = (CODE_W+1)'(NUM_EXC);

    always_comb begin
        legal_o = (code_i != '0) && ({1'b0, code_i} < LIMIT);
    end
endmodule

// File: rtl/exc_frame_calc.sv
module exc_frame_calc
    import exc_entry_pkg::*;
#(
    parameter int CODE_W    = 4,
    parameter int VEC_SHIFT = 8,
    parameter int PC_STEP   = 4
) (
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   sr_i,
    input  logic              dslot_i,
    input  logic              syscall_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [XLEN-1:0]   epc_o,
    output logic [XLEN-1:0]   new_sr_o,
    output logic [XLEN-1:0]   vector_o
);
    localparam logic [XLEN-1:0] CLR_MASK =
        (XLEN'(1) << SR_TICKE) | (XLEN'(1) << SR_INTE) |
        (XLEN'(1) << SR_DTRE)  | (XLEN'(1) << SR_ITRE);
    localparam logic [XLEN-1:0] SUPV_BIT = XLEN'(1) << SR_SUPV;
    localparam logic [XLEN-1:0] DSLX_BIT = XLEN'(1) << SR_DSLX;
    localparam logic [XLEN-1:0] STEP     = XLEN'(PC_STEP);

    logic [XLEN-1:0] epc_ds;

    always_comb begin
        epc_ds   = dslot_i ? (pc_i - STEP) : pc_i;
        epc_o    = syscall_i ? (epc_ds + STEP) : epc_ds;
        new_sr_o = (sr_i & ~CLR_MASK) | SUPV_BIT;
        if (dslot_i) begin
            new_sr_o = new_sr_o | DSLX_BIT;
        end
        vector_o = XLEN'(code_i) << VEC_SHIFT;
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int NUM_EXC      = 15,
    parameter int SYSCALL_CODE = 12,
    parameter int TICK_CODE    = 5,
    parameter int HWINT_CODE   = 8,
    parameter int VEC_SHIFT    = 8,
    parameter int PC_STEP      = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [31:0]       cur_pc_i,
    input  logic [31:0]       cur_sr_i,
    input  logic              in_dslot_i,
    input  logic              exc_req_i,
    input  logic [3:0]        exc_code_i,
    input  logic              hw_irq_i,
    input  logic              tick_irq_i,
    input  logic              rfe_i,
    output logic              redir_vld_o,
    output logic [31:0]       redir_pc_o,
    output logic [31:0]       redir_sr_o,
    output logic [31:0]       epc_o,
    output logic [31:0]       esr_o,
    output logic              tlb_flush_o,
    output logic              dslot_clr_o,
    output logic              bad_code_o,
    output logic [3:0]        taken_code_o
);
    state_t st_d, st_q;

    logic              irq_take;
    logic [CODE_W-1:0] irq_code;
    logic              pend_legal;
    logic [CODE_W-1:0] sel_code;
    logic              sel_syscall;
    logic [XLEN-1:0]   f_epc;
    logic [XLEN-1:0]   f_sr;
    logic [XLEN-1:0]   f_vec;

    exc_irq_arb #(
        .CODE_W    (CODE_W),
        .TICK_CODE (TICK_CODE),
        .HWINT_CODE(HWINT_CODE)
    ) u_arb (
        .hw_irq_i  (hw_irq_i),
        .tick_irq_i(tick_irq_i),
        .int_en_i  (cur_sr_i[SR_INTE]),
        .tick_en_i (cur_sr_i[SR_TICKE]),
        .take_o    (irq_take),
        .code_o    (irq_code)
    );

    exc_code_check #(
        .CODE_W (CODE_W),
        .NUM_EXC(NUM_EXC)
    ) u_chk_code (
        .code_i (st_q.pend.code),
        .legal_o(pend_legal)
    );

    always_comb begin
        sel_code    = st_q.pend.vld ? st_q.pend.code : irq_code;
        sel_syscall = st_q.pend.vld && (st_q.pend.code == CODE_W'(SYSCALL_CODE));
    end

    exc_frame_calc #(
        .CODE_W   (CODE_W),
        .VEC_SHIFT(VEC_SHIFT),
        .PC_STEP  (PC_STEP)
    ) u_frame (
        .pc_i     (cur_pc_i),
        .sr_i     (cur_sr_i),
        .dslot_i  (in_dslot_i),
        .syscall_i(sel_syscall),
        .code_i   (sel_code),
        .epc_o    (f_epc),
        .new_sr_o (f_sr),
        .vector_o (f_vec)
    );

    always_comb begin
        logic enter;
        st_d           = st_q;
        st_d.redir_vld = 1'b0;
        st_d.flush     = 1'b0;
        st_d.dclr      = 1'b0;
        st_d.bad       = 1'b0;
        enter          = 1'b0;

        // a request is held for exactly one cycle, then consumed
        st_d.pend.vld  = exc_req_i;
        st_d.pend.code = exc_req_i ? exc_code_i : '0;

        if (st_q.pend.vld) begin
            if (pend_legal) begin
                enter = 1'b1;
            end else begin
                st_d.bad = 1'b1;
            end
        end else if (irq_take) begin
            enter = 1'b1;
        end else if (rfe_i) begin
            st_d.redir_vld = 1'b1;
            st_d.redir_pc  = st_q.epc;
            st_d.redir_sr  = st_q.esr;
        end

        if (enter) begin
            st_d.redir_vld = 1'b1;
            st_d.redir_pc  = f_vec;
            st_d.redir_sr  = f_sr;
            st_d.epc       = f_epc;
            st_d.esr       = cur_sr_i;
            st_d.flush     = 1'b1;
            st_d.dclr      = in_dslot_i;
            st_d.code      = sel_code;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign redir_vld_o  = st_q.redir_vld;
    assign redir_pc_o   = st_q.redir_pc;
    assign redir_sr_o   = st_q.redir_sr;
    assign epc_o        = st_q.epc;
    assign esr_o        = st_q.esr;
    assign tlb_flush_o  = st_q.flush;
    assign dslot_clr_o  = st_q.dclr;
    assign bad_code_o   = st_q.bad;
    assign taken_code_o = st_q.code;
endmodule

// File: rtl/exc_entry_checker.sv
module exc_entry_checker (
    input logic        clk_i,
    input logic        rst_ni,
    input logic [31:0] cur_sr_i,
    input logic        redir_vld_o,
    input logic [31:0] redir_pc_o,
    input logic [31:0] redir_sr_o,
    input logic [31:0] epc_o,
    input logic [31:0] esr_o,
    input logic        tlb_flush_o,
    input logic        bad_code_o,
    input logic [3:0]  taken_code_o
);
    assert_flush_redirect_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tlb_flush_o |-> redir_vld_o);

    assert_entry_status_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tlb_flush_o |-> (redir_sr_o[0] && !redir_sr_o[1] && !redir_sr_o[2] &&
                         !redir_sr_o[5] && !redir_sr_o[6]));

    assert_saved_status_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tlb_flush_o |-> (esr_o == $past(cur_sr_i)));

    assert_vector_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tlb_flush_o |-> (redir_pc_o == ({28'd0, taken_code_o} << 8)));

    assert_reject_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bad_code_o |-> (!redir_vld_o && $stable(epc_o) && $stable(esr_o)));

    assert_return_restore_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (redir_vld_o && !tlb_flush_o) |-> (redir_pc_o == epc_o && redir_sr_o == esr_o));
endmodule

bind exc_entry_ctrl exc_entry_checker u_entry_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cur_sr_i    (cur_sr_i),
    .redir_vld_o (redir_vld_o),
    .redir_pc_o  (redir_pc_o),
    .redir_sr_o  (redir_sr_o),
    .epc_o       (epc_o),
    .esr_o       (esr_o),
    .tlb_flush_o (tlb_flush_o),
    .bad_code_o  (bad_code_o),
    .taken_code_o(taken_code_o)
);

// File: tb/exc_entry_ctrl_bench.sv
`timescale 1ns/1ps
module exc_entry_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc = '0, sr = '0;
    logic        ds = 1'b0, req = 1'b0, hw = 1'b0, tk = 1'b0, rfe = 1'b0;
    logic [3:0]  code = '0;

    logic        o_vld, o_flush, o_dclr, o_bad;
    logic [31:0] o_pc, o_sr, o_epc, o_esr;
    logic [3:0]  o_code;

    // reference expectations
    logic        m_vld, m_flush, m_dclr, m_bad, m_pend;
    logic [31:0] m_pc, m_sr, m_epc, m_esr;
    logic [3:0]  m_code, m_pcode;

    int    vectors = 0, miscompares = 0, cycles = 0;
    string phase = "R1";
    bit    done = 1'b0;

    always #5 clk = ~clk;

    exc_entry_ctrl u_exc_entry_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .cur_pc_i(pc), .cur_sr_i(sr),
        .in_dslot_i(ds), .exc_req_i(req), .exc_code_i(code),
        .hw_irq_i(hw), .tick_irq_i(tk), .rfe_i(rfe),
        .redir_vld_o(o_vld), .redir_pc_o(o_pc), .redir_sr_o(o_sr),
        .epc_o(o_epc), .esr_o(o_esr), .tlb_flush_o(o_flush),
        .dslot_clr_o(o_dclr), .bad_code_o(o_bad), .taken_code_o(o_code)
    );

    // behavioural reference, one update per clock edge
    always @(posedge clk or negedge rst_n) begin : model
        bit          go;
        int          cause;
        logic [31:0] ret;
        if (!rst_n) begin
            {m_vld, m_flush, m_dclr, m_bad, m_pend} = '0;
            {m_pc, m_sr, m_epc, m_esr} = '0;
            m_code = '0; m_pcode = '0;
        end else begin
            go = 0; cause = 0;
            m_vld = 0; m_flush = 0; m_dclr = 0; m_bad = 0;
            if (m_pend) begin
                if (m_pcode >= 1 && m_pcode <= 14) begin go = 1; cause = m_pcode; end
                else m_bad = 1;
            end else if (tk && sr[1]) begin
                go = 1; cause = 5;
            end else if (hw && sr[2]) begin
                go = 1; cause = 8;
            end else if (rfe) begin
                m_vld = 1; m_pc = m_epc; m_sr = m_esr;
            end
            if (go) begin
                ret = pc;
                if (ds) ret = ret - 4;
                if (m_pend && cause == 12) ret = ret + 4;
                m_epc = ret;
                m_esr = sr;
                m_sr  = sr;
                m_sr[0] = 1'b1;
                m_sr[1] = 1'b0; m_sr[2] = 1'b0; m_sr[5] = 1'b0; m_sr[6] = 1'b0;
                if (ds) m_sr[13] = 1'b1;
                m_pc = cause * 256;
                m_vld = 1; m_flush = 1; m_dclr = ds; m_code = 4'(cause);
            end
            m_pend = req;
            m_pcode = req ? code : 4'd0;
        end
    end

    task automatic chk(string req_tag, logic [31:0] act, logic [31:0] exp);
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s/%s actual=%h expected=%h at cycle %0d", phase, req_tag, act, exp, cycles);
        end
    endtask

    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            vectors++;
            chk("R12_vld",   32'(o_vld),   32'(m_vld));
            chk("R7_pc",     o_pc,         m_pc);
            chk("R6_sr",     o_sr,         m_sr);
            chk("R3_epc",    o_epc,        m_epc);
            chk("R5_esr",    o_esr,        m_esr);
            chk("R10_flush", 32'(o_flush), 32'(m_flush));
            chk("R3_dclr",   32'(o_dclr),  32'(m_dclr));
            chk("R7_bad",    32'(o_bad),   32'(m_bad));
            chk("R9_code",   32'(o_code),  32'(m_code));
            req = 0; hw = 0; tk = 0; rfe = 0;
        end
    endtask

    task automatic excp(logic [3:0] c, logic [31:0] p, logic [31:0] s, logic d);
        req = 1; code = c; cyc(1);
        pc = p; sr = s; ds = d; cyc(1);
        ds = 0; cyc(1);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000 && !done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        // R1: reset values
        @(negedge clk); @(negedge clk);
        vectors++;
        chk("R1", {o_vld, o_flush, o_dclr, o_bad, o_code}, '0);
        chk("R1", o_pc | o_sr | o_epc | o_esr, '0);
        rst_n = 1'b1;
        cyc(1);

        phase = "R2";  excp(4'd3, 32'h0000_1000, 32'h0000_8067, 0); cyc(2);
        phase = "R3";  excp(4'd9, 32'h0000_2040, 32'hFFFF_FFFF, 1);
        phase = "R4";  excp(4'd12, 32'h0000_3000, 32'h0000_0006, 0);
        excp(4'd12, 32'h0000_3104, 32'h0000_0004, 1);
        phase = "R7";  excp(4'd0, 32'h0000_4000, 32'h0000_0006, 0);
        excp(4'd15, 32'h0000_4000, 32'h0000_0006, 0);
        excp(4'd1, 32'h0000_4010, 32'h0000_0000, 0);
        excp(4'd14, 32'h0000_4020, 32'h1234_5678, 0);

        phase = "R8";
        pc = 32'h0000_5000; sr = 32'h0000_0002; hw = 1; cyc(1);   // masked hardware line
        sr = 32'h0000_0004; tk = 1; cyc(1);                        // masked timer line
        sr = 32'h0000_0004; hw = 1; cyc(1);                        // accepted, cause 8
        sr = 32'h0000_0002; tk = 1; cyc(1);                        // accepted, cause 5
        phase = "R9";  sr = 32'h0000_0006; hw = 1; tk = 1; cyc(1);

        phase = "R11"; sr = 32'h0; rfe = 1; cyc(2);

        phase = "R12";
        req = 1; code = 4'd7; cyc(1);
        sr = 32'h0000_0006; hw = 1; tk = 1; rfe = 1; pc = 32'h0000_6000; cyc(1);
        sr = 32'h0000_0006; hw = 1; rfe = 1; cyc(1);
        sr = 32'h0; rfe = 1; cyc(1);
        req = 1; code = 4'd0; cyc(1);
        sr = 32'h0000_0006; tk = 1; cyc(1);
        cyc(1);

        phase = "RND";
        for (int k = 0; k < 4000; k++) begin
            pc   = {$urandom_range(0, 32'h3FFF_FFFF), 2'b00};
            sr   = $urandom;
            ds   = ($urandom_range(0, 3) == 0);
            req  = ($urandom_range(0, 4) == 0);
            code = 4'($urandom_range(0, 15));
            hw   = ($urandom_range(0, 2) == 0);
            tk   = ($urandom_range(0, 2) == 0);
            rfe  = ($urandom_range(0, 3) == 0);
            cyc(1);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule